// File: doc/BRIEF.md
# Dependence-Matrix Selective Replay Tracker

This block is the ancestry-tracking part of a small scheduler window that recovers from mispredicted load latency by selective replay. Every window entry holds one instruction with two source operands. For each operand the entry keeps a small bit matrix. Each column stands for an issue slot and each row for one cycle of the time a load needs before its latency is confirmed. When an entry issues, its two operand matrices are ORed, moved one row down, given the entry's own slot bit in the top row, and driven on the wakeup bus next to its destination tag. Children that are waiting on that tag take both the tag and the matrix.

All matrices move down one row per cycle. An external kill bus names the issue slots whose loads were mispredicted. If a kill bit meets a set bit in the bottom row of an entry's operand matrix, that operand is no longer ready and the entry waits again. If the kill bit meets the entry's own issue record, the entry waits again with its operands still ready, so it can reissue. An issued entry that sees no kill for D cycles frees its slot.

New instructions enter through a valid/ready allocation stream. `alloc_ready` is high whenever at least one entry is free, and it does not depend on `alloc_valid`. A transfer happens on a rising clock edge where both signals are high. The payload has to stay stable while `alloc_valid` is high and `alloc_ready` is low. The block ignores `alloc_valid` during cycles where `alloc_ready` is low. Instruction selection is outside the block: the selector asks for issue through `iss_valid`/`iss_idx` and may only choose entries shown in `entry_ready`.

Top module: `rpl_ancestry_window`

## Requirements
- R1: After reset, no entry is busy, `alloc_ready` is 1, and `wake_valid` is 0.
- R2: An accepted allocation goes into the lowest-numbered free entry, and that entry's `entry_busy` bit is 1 in the next cycle. `alloc_ready` is 0 while all entries are busy, and an allocation offered then changes nothing.
- R3: `entry_ready[i]` is 1 when entry i is waiting and both operands are ready. An operand is ready when it was marked ready at allocation, or when a wakeup on any slot carried its source tag.
- R4: An issue request on slot s for a ready entry drives, in the same cycle, `wake_valid[s]`=1 and `wake_tag` = the entry's destination tag. It also drives `wake_mat` = (OR of the entry's matrices moved down one row) with bit s of row 0 set. Matrix bit (row r, slot c) sits at position r*W+c of a slot's field, and row 0 is the top row.
- R5: A matrix that an operand has captured moves down one row on every following clock edge. Bits leave past the bottom row (row D-1).
- R6: If a set kill bit c meets bit c of an operand matrix's bottom row, that operand is cleared to not ready. The entry then waits again, and `entry_ready` falls on the next cycle.
- R7: An issued entry whose own slot bit reaches the bottom row (D edges after issue) and meets the kill bus returns to waiting with its operands ready. When it reissues, the issue record is fresh.
- R8: An issued entry that is never killed stays busy for D cycles after the issue cycle, and `entry_busy` falls after the D+1-th edge.
- R9: When a kill and the release fall in the same cycle, the kill wins and the entry stays busy.
- R10: An issue request for an entry that is killed in that same cycle broadcasts nothing.
- R11: If two slots request the same entry in one cycle, only the lower-numbered slot broadcasts.
- R12: An allocation snoops the wakeup bus in its own cycle, so a source tag broadcast in that cycle makes the operand ready.
- R13: An issue request for an entry that is not ready produces no broadcast and leaves the entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation offer |
| alloc_ready | output | 1 | A free entry exists |
| alloc_dst | input | TAG_W | Destination tag of the new instruction |
| alloc_src_a | input | TAG_W | Source tag, operand A |
| alloc_src_b | input | TAG_W | Source tag, operand B |
| alloc_rdy_a | input | 1 | Operand A already available |
| alloc_rdy_b | input | 1 | Operand B already available |
| iss_valid | input | W | Issue request per slot |
| iss_idx | input | W*IW | Entry index per slot |
| kill_slots | input | W | Mispredicted-load slots this cycle |
| wake_valid | output | W | Broadcast valid per slot |
| wake_tag | output | W*TAG_W | Broadcast destination tag per slot |
| wake_mat | output | W*W*D | Broadcast ancestry matrix per slot |
| entry_busy | output | N | Entry holds an instruction |
| entry_ready | output | N | Entry may be selected for issue |

## Verification
The collision that matters most is a kill arriving in the same cycle that an issued entry's D-cycle hold ends. The bench creates it by killing the slot of a load exactly D cycles after the load issued. It then expects the entry to stay busy and show ready again, with no release. A second collision is a kill that lands on an entry the selector is requesting in that same cycle. The bench judges this case by the absence of any broadcast and by the entry being not ready afterwards. Two slots requesting one entry and an allocation that meets a matching wakeup are also driven in a single cycle.

// File: rtl/rpl_pkg.sv
package rpl_pkg;

  typedef enum logic [1:0] {
    ENT_FREE   = 2'd0,
    ENT_WAIT   = 2'd1,
    ENT_ISSUED = 2'd2
  } ent_state_e;

endpackage

// File: rtl/rpl_free_pick.sv
module rpl_free_pick #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] busy,
  output logic [N-1:0] grant,
  output logic         any_free
);

  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) grant = N'(1) << i;
    end
  end

  assign any_free = ~&busy;

  AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & busy) == '0)); // R2

endmodule

// File: rtl/rpl_entry.sv
module rpl_entry
  import rpl_pkg::*;
#(
  parameter int W     = 2,
  parameter int D     = 3,
  parameter int TAG_W = 4,
  localparam int M    = W * D,
  localparam int SW   = (W > 1) ? $clog2(W) : 1,
  localparam int AW   = $clog2(D + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_we,
  input  logic [TAG_W-1:0] alloc_dst,
  input  logic [TAG_W-1:0] alloc_src_a,
  input  logic [TAG_W-1:0] alloc_src_b,
  input  logic             alloc_rdy_a,
  input  logic             alloc_rdy_b,
  input  logic             issue_hit,
  input  logic [SW-1:0]    issue_slot,
  input  logic [W-1:0]     wk_valid,
  input  logic [W*TAG_W-1:0] wk_tag,
  input  logic [W*M-1:0]   wk_mat,
  input  logic [W-1:0]     kill,
  output logic             busy,
  output logic             can_issue,
  output logic             kill_hit,
  output logic [TAG_W-1:0] dst_tag,
  output logic [M-1:0]     bcast_base
);

  ent_state_e       st_q;
  logic [TAG_W-1:0] dst_q, src_a_q, src_b_q;
  logic             rdy_a_q, rdy_b_q;
  logic [M-1:0]     mat_a_q, mat_b_q, own_q;
  logic [AW-1:0]    age_q;

  logic             hit_a, hit_b, hit_o;
  logic [TAG_W-1:0] snoop_a, snoop_b;
  logic             cap_a, cap_b;
  logic [M-1:0]     cap_mat_a, cap_mat_b;
  logic             upd_rdy_a, upd_rdy_b;
  logic [M-1:0]     upd_mat_a, upd_mat_b;
  logic [M-1:0]     self_row;
  logic             age_done;

  // bottom row = row D-1, the highest W bits
  assign hit_a    = |(mat_a_q[M-1 -: W] & kill);
  assign hit_b    = |(mat_b_q[M-1 -: W] & kill);
  assign hit_o    = |(own_q[M-1 -: W] & kill);
  assign kill_hit = (st_q != ENT_FREE) && (hit_a || hit_b || hit_o);

  assign busy       = (st_q != ENT_FREE);
  assign can_issue  = (st_q == ENT_WAIT) && rdy_a_q && rdy_b_q;
  assign dst_tag    = dst_q;
  assign bcast_base = (mat_a_q | mat_b_q | own_q) << W;
  assign self_row   = M'(1) << issue_slot;
  assign age_done   = (age_q == AW'(D));

  assign snoop_a = (st_q == ENT_FREE) ? alloc_src_a : src_a_q;
  assign snoop_b = (st_q == ENT_FREE) ? alloc_src_b : src_b_q;

  always_comb begin
    cap_a     = 1'b0;
    cap_b     = 1'b0;
    cap_mat_a = '0;
    cap_mat_b = '0;
    for (int s = 0; s < W; s++) begin
      if (wk_valid[s] && (wk_tag[s*TAG_W +: TAG_W] == snoop_a)) begin
        cap_a     = 1'b1;
        cap_mat_a = wk_mat[s*M +: M];
      end
      if (wk_valid[s] && (wk_tag[s*TAG_W +: TAG_W] == snoop_b)) begin
        cap_b     = 1'b1;
        cap_mat_b = wk_mat[s*M +: M];
      end
    end
  end

  always_comb begin
    if (!rdy_a_q && cap_a) begin
      upd_rdy_a = 1'b1;
      upd_mat_a = cap_mat_a;
    end else begin
      upd_rdy_a = rdy_a_q;
      upd_mat_a = mat_a_q << W;
    end
    if (!rdy_b_q && cap_b) begin
      upd_rdy_b = 1'b1;
      upd_mat_b = cap_mat_b;
    end else begin
      upd_rdy_b = rdy_b_q;
      upd_mat_b = mat_b_q << W;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ENT_FREE;
      dst_q   <= '0;
      src_a_q <= '0;
      src_b_q <= '0;
      rdy_a_q <= 1'b0;
      rdy_b_q <= 1'b0;
      mat_a_q <= '0;
      mat_b_q <= '0;
      own_q   <= '0;
      age_q   <= '0;
    end else begin
      case (st_q)
        ENT_FREE: begin
          if (alloc_we) begin
            st_q    <= ENT_WAIT;
            dst_q   <= alloc_dst;
            src_a_q <= alloc_src_a;
            src_b_q <= alloc_src_b;
            rdy_a_q <= alloc_rdy_a | cap_a;
            rdy_b_q <= alloc_rdy_b | cap_b;
            mat_a_q <= (!alloc_rdy_a && cap_a) ? cap_mat_a : '0;
            mat_b_q <= (!alloc_rdy_b && cap_b) ? cap_mat_b : '0;
            own_q   <= '0;
            age_q   <= '0;
          end
        end
        default: begin
          if (kill_hit) begin
            st_q    <= ENT_WAIT;
            own_q   <= '0;
            age_q   <= '0;
            rdy_a_q <= hit_a ? 1'b0 : upd_rdy_a;
            mat_a_q <= hit_a ? '0 : upd_mat_a;
            rdy_b_q <= hit_b ? 1'b0 : upd_rdy_b;
            mat_b_q <= hit_b ? '0 : upd_mat_b;
          end else if (issue_hit) begin
            st_q    <= ENT_ISSUED;
            own_q   <= self_row;
            age_q   <= AW'(1);
            rdy_a_q <= upd_rdy_a;
            mat_a_q <= upd_mat_a;
            rdy_b_q <= upd_rdy_b;
            mat_b_q <= upd_mat_b;
          end else if ((st_q == ENT_ISSUED) && age_done) begin
            st_q    <= ENT_FREE;
            rdy_a_q <= 1'b0;
            rdy_b_q <= 1'b0;
            mat_a_q <= '0;
            mat_b_q <= '0;
            own_q   <= '0;
            age_q   <= '0;
          end else begin
            rdy_a_q <= upd_rdy_a;
            mat_a_q <= upd_mat_a;
            rdy_b_q <= upd_rdy_b;
            mat_b_q <= upd_mat_b;
            own_q   <= own_q << W;
            if (st_q == ENT_ISSUED) age_q <= age_q + AW'(1);
          end
        end
      endcase
    end
  end

  AST_AGE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENT_ISSUED) |-> ((age_q >= AW'(1)) && (age_q <= AW'(D)))); // R8

  AST_KILL_REWAIT: assert property (@(posedge clk) disable iff (!rst_n)
    kill_hit |=> (st_q == ENT_WAIT)); // R6

  AST_KILL_BEATS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ENT_ISSUED) && age_done && kill_hit) |=> busy); // R9

  AST_ISSUE_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_hit |-> (can_issue && !kill_hit)); // R10

  AST_OWN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(own_q)); // R7

endmodule

// File: rtl/rpl_wake_bus.sv
module rpl_wake_bus #(
  parameter int N     = 4,
  parameter int W     = 2,
  parameter int D     = 3,
  parameter int TAG_W = 4,
  localparam int M    = W * D,
  localparam int SW   = (W > 1) ? $clog2(W) : 1,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         iss_valid,
  input  logic [W*IW-1:0]      iss_idx,
  input  logic [N-1:0]         can_issue,
  input  logic [N-1:0]         kill_hit,
  input  logic [N*TAG_W-1:0]   dst_flat,
  input  logic [N*M-1:0]       base_flat,
  output logic [W-1:0]         wake_valid,
  output logic [W*TAG_W-1:0]   wake_tag,
  output logic [W*M-1:0]       wake_mat,
  output logic [N-1:0]         ent_hit,
  output logic [N*SW-1:0]      ent_slot
);

  always_comb begin
    logic [IW-1:0] ix;
    logic          dup;
    logic          ok;
    wake_valid = '0;
    wake_tag   = '0;
    wake_mat   = '0;
    ent_hit    = '0;
    ent_slot   = '0;
    for (int s = 0; s < W; s++) begin
      ix  = iss_idx[s*IW +: IW];
      dup = 1'b0;
      for (int p = 0; p < s; p++) begin
        if (iss_valid[p] && (iss_idx[p*IW +: IW] == ix)) dup = 1'b1;
      end
      ok = iss_valid[s] && !dup && (int'(ix) < N);
      if (ok) ok = can_issue[ix] && !kill_hit[ix];
      if (ok) begin
        wake_valid[s]              = 1'b1;
        wake_tag[s*TAG_W +: TAG_W] = dst_flat[ix*TAG_W +: TAG_W];
        wake_mat[s*M +: M]         = base_flat[ix*M +: M] | (M'(1) << s);
        ent_hit[ix]                = 1'b1;
        ent_slot[ix*SW +: SW]      = SW'(s);
      end
    end
  end

  AST_ONE_BROADCAST_PER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wake_valid) == $countones(ent_hit)); // R11

endmodule

// File: rtl/rpl_ancestry_window.sv
module rpl_ancestry_window #(
  parameter int N     = 4,
  parameter int W     = 2,
  parameter int D     = 3,
  parameter int TAG_W = 4,
  localparam int M    = W * D,
  localparam int SW   = (W > 1) ? $clog2(W) : 1,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  output logic               alloc_ready,
  input  logic [TAG_W-1:0]   alloc_dst,
  input  logic [TAG_W-1:0]   alloc_src_a,
  input  logic [TAG_W-1:0]   alloc_src_b,
  input  logic               alloc_rdy_a,
  input  logic               alloc_rdy_b,
  input  logic [W-1:0]       iss_valid,
  input  logic [W*IW-1:0]    iss_idx,
  input  logic [W-1:0]       kill_slots,
  output logic [W-1:0]       wake_valid,
  output logic [W*TAG_W-1:0] wake_tag,
  output logic [W*M-1:0]     wake_mat,
  output logic [N-1:0]       entry_busy,
  output logic [N-1:0]       entry_ready
);

  logic [N-1:0]       pick;
  logic [N-1:0]       kill_hit;
  logic [N*TAG_W-1:0] dst_flat;
  logic [N*M-1:0]     base_flat;
  logic [N-1:0]       ent_hit;
  logic [N*SW-1:0]    ent_slot;
  logic               accept;

  assign accept = alloc_valid && alloc_ready;

  rpl_free_pick #(.N(N)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (entry_busy),
    .grant    (pick),
    .any_free (alloc_ready)
  );

  rpl_wake_bus #(.N(N), .W(W), .D(D), .TAG_W(TAG_W)) u_wake (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_idx    (iss_idx),
    .can_issue  (entry_ready),
    .kill_hit   (kill_hit),
    .dst_flat   (dst_flat),
    .base_flat  (base_flat),
    .wake_valid (wake_valid),
    .wake_tag   (wake_tag),
    .wake_mat   (wake_mat),
    .ent_hit    (ent_hit),
    .ent_slot   (ent_slot)
  );

  for (genvar i = 0; i < N; i++) begin : g_ent
    rpl_entry #(.W(W), .D(D), .TAG_W(TAG_W)) u_ent (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_we    (accept && pick[i]),
      .alloc_dst   (alloc_dst),
      .alloc_src_a (alloc_src_a),
      .alloc_src_b (alloc_src_b),
      .alloc_rdy_a (alloc_rdy_a),
      .alloc_rdy_b (alloc_rdy_b),
      .issue_hit   (ent_hit[i]),
      .issue_slot  (ent_slot[i*SW +: SW]),
      .wk_valid    (wake_valid),
      .wk_tag      (wake_tag),
      .wk_mat      (wake_mat),
      .kill        (kill_slots),
      .busy        (entry_busy[i]),
      .can_issue   (entry_ready[i]),
      .kill_hit    (kill_hit[i]),
      .dst_tag     (dst_flat[i*TAG_W +: TAG_W]),
      .bcast_base  (base_flat[i*M +: M])
    );
  end

  AST_ALLOC_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> |(entry_busy & $past(pick))); // R2

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (&entry_busy) |-> !alloc_ready); // R2

endmodule

// File: tb/rpl_ancestry_window_test.sv
module rpl_ancestry_window_test;

  localparam int N  = 4;
  localparam int W  = 2;
  localparam int D  = 3;
  localparam int TW = 4;
  localparam int IW = 2;
  localparam int M  = W * D;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              alloc_valid;
  logic              alloc_ready;
  logic [TW-1:0]     alloc_dst, alloc_src_a, alloc_src_b;
  logic              alloc_rdy_a, alloc_rdy_b;
  logic [W-1:0]      iss_valid;
  logic [W*IW-1:0]   iss_idx;
  logic [W-1:0]      kill_slots;
  logic [W-1:0]      wake_valid;
  logic [W*TW-1:0]   wake_tag;
  logic [W*M-1:0]    wake_mat;
  logic [N-1:0]      entry_busy, entry_ready;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rpl_ancestry_window #(.N(N), .W(W), .D(D), .TAG_W(TW)) uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_dst(alloc_dst), .alloc_src_a(alloc_src_a), .alloc_src_b(alloc_src_b),
    .alloc_rdy_a(alloc_rdy_a), .alloc_rdy_b(alloc_rdy_b),
    .iss_valid(iss_valid), .iss_idx(iss_idx), .kill_slots(kill_slots),
    .wake_valid(wake_valid), .wake_tag(wake_tag), .wake_mat(wake_mat),
    .entry_busy(entry_busy), .entry_ready(entry_ready)
  );

  // {valid, dst, src_a, src_b, rdy_a, rdy_b, exp alloc_ready, exp busy, exp ready}
  localparam logic [23:0] TBL [5] = '{
    {1'b1, 4'd1, 4'd0, 4'd0, 1'b1, 1'b1, 1'b1, 4'b0001, 4'b0001},
    {1'b1, 4'd2, 4'd1, 4'd0, 1'b0, 1'b1, 1'b1, 4'b0011, 4'b0001},
    {1'b1, 4'd3, 4'd2, 4'd1, 1'b0, 1'b0, 1'b1, 4'b0111, 4'b0001},
    {1'b1, 4'd4, 4'd0, 4'd0, 1'b1, 1'b1, 1'b1, 4'b1111, 4'b1001},
    {1'b1, 4'd9, 4'd0, 4'd0, 1'b1, 1'b1, 1'b0, 4'b1111, 4'b1001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic quiet();
    alloc_valid = 1'b0;
    alloc_dst   = '0;
    alloc_src_a = '0;
    alloc_src_b = '0;
    alloc_rdy_a = 1'b0;
    alloc_rdy_b = 1'b0;
    iss_valid   = '0;
    iss_idx     = '0;
    kill_slots  = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    quiet();
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    #1;
    chk("R1 busy after reset", 32'(entry_busy), 32'd0);
    chk("R1 alloc_ready after reset", 32'(alloc_ready), 32'd1);
    chk("R1 wake_valid after reset", 32'(wake_valid), 32'd0);

    // Table: fill the window, then offer one allocation while full
    for (int i = 0; i < 5; i++) begin
      logic [23:0] v;
      v = TBL[i];
      alloc_valid = v[23];
      alloc_dst   = v[22:19];
      alloc_src_a = v[18:15];
      alloc_src_b = v[14:11];
      alloc_rdy_a = v[10];
      alloc_rdy_b = v[9];
      #1;
      chk("R2 alloc_ready", 32'(alloc_ready), 32'(v[8]));
      tick();
      #1;
      chk("R2 busy after alloc", 32'(entry_busy), 32'(v[7:4]));
      chk("R3 ready after alloc", 32'(entry_ready), 32'(v[3:0]));
    end
    quiet();

    // t0: entry0 issues on slot 0
    iss_valid = 2'b01; iss_idx = {2'd0, 2'd0};
    #1;
    chk("R4 wake_valid", 32'(wake_valid), 32'b01);
    chk("R4 wake_tag", 32'(wake_tag[3:0]), 32'd1);
    chk("R4 wake_mat", 32'(wake_mat[5:0]), 32'b000001);
    tick(); quiet(); #1;
    chk("R3 capture by tag", 32'(entry_ready), 32'b1010);

    // t1: entry1 issues on slot 1
    iss_valid = 2'b10; iss_idx = {2'd1, 2'd0};
    #1;
    chk("R4 wake slot1 valid", 32'(wake_valid), 32'b10);
    chk("R4 wake slot1 tag", 32'(wake_tag[7:4]), 32'd2);
    chk("R5 wake slot1 mat", 32'(wake_mat[11:6]), 32'b000110);
    tick(); quiet(); #1;
    chk("R3 second child ready", 32'(entry_ready), 32'b1100);

    // t2: entry2 issues on slot 0
    iss_valid = 2'b01; iss_idx = {2'd0, 2'd2};
    #1;
    chk("R5 shifted merge", 32'(wake_mat[5:0]), 32'b011001);
    chk("R4 grandchild tag", 32'(wake_tag[3:0]), 32'd3);
    tick(); quiet(); #1;
    chk("R3 ready after t2", 32'(entry_ready), 32'b1000);

    // t3: kill slot 0 exactly D cycles after entry0 issued
    kill_slots = 2'b01;
    tick(); quiet(); #1;
    chk("R9 killed load not released", 32'(entry_busy[0]), 32'd1);
    chk("R7 killed load ready again", 32'(entry_ready[0]), 32'd1);
    chk("R6 dependent not ready", 32'(entry_ready[1]), 32'd0);
    chk("R6 dependent still busy", 32'(entry_busy[1]), 32'd1);
    chk("R6 ready vector", 32'(entry_ready), 32'b1001);

    // t4: entry0 reissues on slot 1
    iss_valid = 2'b10; iss_idx = {2'd0, 2'd0};
    #1;
    chk("R7 reissue valid", 32'(wake_valid), 32'b10);
    chk("R7 reissue tag", 32'(wake_tag[7:4]), 32'd1);
    chk("R7 fresh record", 32'(wake_mat[11:6]), 32'b000010);
    tick(); quiet(); #1;
    chk("R3 after reissue", 32'(entry_ready), 32'b1010);

    // t5: entry3 issues on slot 0
    iss_valid = 2'b01; iss_idx = {2'd0, 2'd3};
    #1;
    chk("R4 entry3 broadcast", 32'(wake_mat[5:0]), 32'b000001);
    tick(); quiet(); #1;
    chk("R3 after t5", 32'(entry_ready), 32'b0010);

    // t6: idle
    tick(); #1;

    // t7: issue request for entry1 while kill slot 1 hits it
    iss_valid = 2'b10; iss_idx = {2'd1, 2'd0}; kill_slots = 2'b10;
    #1;
    chk("R10 no broadcast on kill", 32'(wake_valid), 32'b00);
    tick(); quiet(); #1;
    chk("R10 ready after kill", 32'(entry_ready), 32'b0001);
    chk("R8 still held at D", 32'(entry_busy[3]), 32'd1);

    // t8: idle, entry3 released
    tick(); #1;
    chk("R8 released", 32'(entry_busy), 32'b0111);

    // t9: allocate while entry0 is requested on both slots
    alloc_valid = 1'b1; alloc_dst = 4'd5; alloc_src_a = 4'd1; alloc_rdy_a = 1'b0;
    alloc_src_b = 4'd0; alloc_rdy_b = 1'b1;
    iss_valid = 2'b11; iss_idx = {2'd0, 2'd0};
    #1;
    chk("R2 alloc_ready with free entry", 32'(alloc_ready), 32'd1);
    chk("R11 one broadcast", 32'(wake_valid), 32'b01);
    chk("R11 tag", 32'(wake_tag[3:0]), 32'd1);
    tick(); quiet(); #1;
    chk("R2 busy after alloc", 32'(entry_busy), 32'b1111);
    chk("R12 snoop on alloc", 32'(entry_ready), 32'b1010);

    // t10: request a non-ready entry
    iss_valid = 2'b01; iss_idx = {2'd0, 2'd2};
    #1;
    chk("R13 no broadcast", 32'(wake_valid), 32'b00);
    tick(); quiet(); #1;
    chk("R13 entry unchanged", 32'(entry_ready), 32'b1010);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule